// File: doc/BRIEF.md
# Blocking Data Cache with Store Queue

This block is a direct-mapped, write-back, write-allocate data cache that stands between a processor pipeline and a memory port that moves whole lines. Every processor request lands first in a one-entry bypass buffer. A request can therefore be examined in the cycle it arrives, and a load that hits answers on the next clock edge. A central controller takes requests out of that buffer. Stores are placed in an in-order store queue and retire from there into the array later. Loads are answered from the youngest matching queued store, or else from the array.

The cache handles one line miss at a time. Its miss controller steps through four states: ready, start-miss (write back a dirty victim), send-fill (request the line) and wait-fill. While a queued store waits for its line, a load at the head of the buffer can still finish if it hits in the store queue or in the array. A load that misses waits in the buffer. A load miss blocks every later load, so responses come back in program order. The memory accepts a request when `mem_req_ready` is high. It returns exactly one `mem_resp_valid` pulse for every line read. The processor takes a response in the cycle `resp_valid` is high.

Top module: `dcache_stbuf`

## Requirements
- R1: The request buffer holds one entry and passes requests straight through when empty. A load that hits the array and is accepted on clock edge t raises `resp_valid` with its data in the cycle that follows edge t. `req_ready` is low only while the entry is occupied.
- R2: A store enters the store queue only when it leaves the request buffer. A load followed by a store to the same word returns the older value. A store followed by a load to the same word returns the stored value.
- R3: In the ready state, a load at the head of the buffer is served before any queued store is issued. If that load misses, its line read goes to memory before the line read of a store that was queued earlier.
- R4: Queued stores keep issuing while the head of the buffer is a store. A run of stores longer than the queue completes without deadlock.
- R5: A store leaves the queue only when it writes the array. A store hit issues and writes in one cycle. A store miss stays queued until its line arrives, so a load to that word during the miss is answered one cycle after acceptance.
- R6: While a store miss waits for its line, a load at the buffer head that hits in the array completes one cycle after acceptance. A load that misses stays in the buffer.
- R7: No load response is produced while a load miss is outstanding. A later load hit returns after the missing load's data, and responses stay in program order.
- R8: A load matching one or more queued stores to the same word returns the data of the youngest of them.
- R9: Replacing a dirty line first writes the whole victim line to memory (`mem_req_write`=1) and then reads the new line. Replacing a clean line issues no write. Addresses are word addresses: the low log2(words per line) bits select the word, the next log2(lines) bits the index, and the rest form the tag. `mem_req_addr` is the word address with the word bits removed.
- R10: Once raised, `mem_req_valid` stays high, with address and direction held, until `mem_req_ready` accepts it. Data stays correct when memory stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request buffer can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | Load data valid this cycle |
| resp_data | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_req_line | output | DATA_W*LINE_WORDS | Write-back line data |
| mem_resp_valid | input | 1 | Fill line present |
| mem_resp_line | input | DATA_W*LINE_WORDS | Fill line data |

## Verification
The bench targets the cases where two requests compete for the controller:
- A load that waits behind a store miss. A design that blocks it answers only after the fill instead of one cycle after acceptance.
- A load to a word whose store is still missing. Dequeuing the store at issue would make that load wait for memory.
- A load queued behind two store misses. The bench checks the order of memory reads to confirm the load's line read jumps ahead of the second store.
- A long run of stores. A controller that stops draining while a store sits at the head of the buffer hangs.

Dirty and clean evictions are checked against the write-back count and the memory contents, including while memory stalls on alternate cycles. A reference model of program order checks every load value and its response order.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        ST_READY      = 2'd0,
        ST_START_MISS = 2'd1,
        ST_SEND_FILL  = 2'd2,
        ST_WAIT_FILL  = 2'd3
    } miss_state_e;
endpackage

// File: rtl/dcs_reqq.sv
// One-entry bypass buffer: the head shows the incoming request when empty.
module dcs_reqq #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_store,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          head_valid,
    output logic          head_store,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    input  logic          deq
);
    logic          full_q, full_d;
    logic          store_q, store_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [DW-1:0] data_q, data_d;

    assign in_ready   = !full_q;
    assign head_valid = full_q || in_valid;
    assign head_store = full_q ? store_q : in_store;
    assign head_addr  = full_q ? addr_q  : in_addr;
    assign head_data  = full_q ? data_q  : in_data;

    always_comb begin
        full_d  = full_q;
        store_d = store_q;
        addr_d  = addr_q;
        data_d  = data_q;
        if (full_q) begin
            if (deq) full_d = 1'b0;
        end else if (in_valid && !deq) begin
            full_d  = 1'b1;
            store_d = in_store;
            addr_d  = in_addr;
            data_d  = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            store_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            full_q  <= full_d;
            store_q <= store_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
        end
    end
endmodule

// File: rtl/dcs_stq.sv
// In-order store queue with issue flag and youngest-match search.
module dcs_stq #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic [AW-1:0] enq_addr,
    input  logic [DW-1:0] enq_data,
    output logic          full,
    output logic          empty,
    input  logic          issue,
    output logic          issued,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    input  logic          deq,
    input  logic [AW-1:0] srch_addr,
    output logic          srch_hit,
    output logic [DW-1:0] srch_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [AW-1:0]    addr_mem [DEPTH];
    logic [DW-1:0]    data_mem [DEPTH];
    logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             issued_q, issued_d;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign issued    = issued_q;
    assign head_addr = addr_mem[head_q];
    assign head_data = data_mem[head_q];

    always_comb begin
        int slot;
        srch_hit  = 1'b0;
        srch_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = int'(head_q) + i;
            if (slot >= DEPTH) slot = slot - DEPTH;
            if (i < int'(cnt_q) && addr_mem[slot[PTR_W-1:0]] == srch_addr) begin
                srch_hit  = 1'b1;
                srch_data = data_mem[slot[PTR_W-1:0]];
            end
        end
    end

    always_comb begin
        head_d   = head_q;
        tail_d   = tail_q;
        cnt_d    = cnt_q;
        issued_d = issued_q;
        if (enq) begin
            tail_d = (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
        end
        if (deq) begin
            head_d = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        end
        if (enq && !deq) cnt_d = cnt_q + 1'b1;
        else if (deq && !enq) cnt_d = cnt_q - 1'b1;
        if (deq) issued_d = 1'b0;
        else if (issue) issued_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= '0;
            cnt_q    <= '0;
            issued_q <= 1'b0;
        end else begin
            head_q   <= head_d;
            tail_q   <= tail_d;
            cnt_q    <= cnt_d;
            issued_q <= issued_d;
        end
    end

    always_ff @(posedge clk) begin
        if (enq) begin
            addr_mem[tail_q] <= enq_addr;
            data_mem[tail_q] <= enq_data;
        end
    end
endmodule

// File: rtl/dcs_array.sv
// Direct-mapped tag, state and line storage; one read index, one line write.
module dcs_array #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 27,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINES-1:0] valid_q, dirty_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] line_mem [LINES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_line  = line_mem[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/dcache_stbuf.sv
module dcache_stbuf
    import dcs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 8,
    parameter int SQ_DEPTH   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic                                   req_store,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   resp_valid,
    output logic [DATA_W-1:0]                      resp_data,
    output logic                                   mem_req_valid,
    input  logic                                   mem_req_ready,
    output logic                                   mem_req_write,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]   mem_req_addr,
    output logic [DATA_W*LINE_WORDS-1:0]           mem_req_line,
    input  logic                                   mem_resp_valid,
    input  logic [DATA_W*LINE_WORDS-1:0]           mem_resp_line
);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W  = DATA_W * LINE_WORDS;

    typedef struct packed {
        miss_state_e       state;
        logic              miss_store;
        logic [ADDR_W-1:0] miss_addr;
        logic [DATA_W-1:0] miss_data;
        logic              resp_valid;
        logic [DATA_W-1:0] resp_data;
    } ctrl_t;

    ctrl_t ctrl_q, ctrl_d;

    logic              head_valid, head_store, reqq_deq;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;

    logic              stq_enq, stq_full, stq_empty, stq_issue, stq_issued, stq_deq;
    logic [ADDR_W-1:0] stq_head_addr;
    logic [DATA_W-1:0] stq_head_data;
    logic              srch_hit;
    logic [DATA_W-1:0] srch_data;

    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic              arr_wr_en, arr_wr_dirty;
    logic [IDX_W-1:0]  arr_wr_idx;
    logic [TAG_W-1:0]  arr_wr_tag;
    logic [LINE_W-1:0] arr_wr_line;

    dcs_reqq #(.AW(ADDR_W), .DW(DATA_W)) u_reqq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_ready(req_ready), .in_store(req_store),
        .in_addr(req_addr), .in_data(req_wdata),
        .head_valid(head_valid), .head_store(head_store),
        .head_addr(head_addr), .head_data(head_data), .deq(reqq_deq)
    );

    dcs_stq #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(SQ_DEPTH)) u_stq (
        .clk(clk), .rst_n(rst_n),
        .enq(stq_enq), .enq_addr(head_addr), .enq_data(head_data),
        .full(stq_full), .empty(stq_empty),
        .issue(stq_issue), .issued(stq_issued),
        .head_addr(stq_head_addr), .head_data(stq_head_data), .deq(stq_deq),
        .srch_addr(head_addr), .srch_hit(srch_hit), .srch_data(srch_data)
    );

    dcs_array #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(arr_wr_en), .wr_idx(arr_wr_idx), .wr_tag(arr_wr_tag),
        .wr_dirty(arr_wr_dirty), .wr_line(arr_wr_line)
    );

    function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [OFF_W-1:0] off);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < LINE_WORDS; k++)
            if (off == k[OFF_W-1:0]) w = line[k*DATA_W +: DATA_W];
        return w;
    endfunction

    function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [DATA_W-1:0] w);
        logic [LINE_W-1:0] l;
        l = line;
        for (int k = 0; k < LINE_WORDS; k++)
            if (off == k[OFF_W-1:0]) l[k*DATA_W +: DATA_W] = w;
        return l;
    endfunction

    logic head_is_load, head_hit, stq_head_hit;

    assign head_is_load = head_valid && !head_store;
    assign head_hit     = rd_valid && (rd_tag == head_addr[ADDR_W-1 -: TAG_W]);
    assign stq_head_hit = rd_valid && (rd_tag == stq_head_addr[ADDR_W-1 -: TAG_W]);

    always_comb begin
        case (ctrl_q.state)
            ST_READY:      rd_idx = head_is_load ? head_addr[OFF_W +: IDX_W]
                                                 : stq_head_addr[OFF_W +: IDX_W];
            ST_START_MISS: rd_idx = ctrl_q.miss_addr[OFF_W +: IDX_W];
            default:       rd_idx = head_addr[OFF_W +: IDX_W];
        endcase
    end

    always_comb begin
        ctrl_d            = ctrl_q;
        ctrl_d.resp_valid = 1'b0;
        reqq_deq          = 1'b0;
        stq_enq           = 1'b0;
        stq_issue         = 1'b0;
        stq_deq           = 1'b0;
        arr_wr_en         = 1'b0;
        arr_wr_dirty      = 1'b0;
        arr_wr_idx        = ctrl_q.miss_addr[OFF_W +: IDX_W];
        arr_wr_tag        = ctrl_q.miss_addr[ADDR_W-1 -: TAG_W];
        arr_wr_line       = mem_resp_line;
        mem_req_valid     = 1'b0;
        mem_req_write     = 1'b0;
        mem_req_addr      = ctrl_q.miss_addr[ADDR_W-1:OFF_W];
        mem_req_line      = rd_line;

        // stores move into the queue in any state, when they leave the buffer
        if (head_valid && head_store && !stq_full) begin
            stq_enq  = 1'b1;
            reqq_deq = 1'b1;
        end

        case (ctrl_q.state)
            ST_READY: begin
                if (head_is_load) begin
                    reqq_deq = 1'b1;
                    if (srch_hit) begin
                        ctrl_d.resp_valid = 1'b1;
                        ctrl_d.resp_data  = srch_data;
                    end else if (head_hit) begin
                        ctrl_d.resp_valid = 1'b1;
                        ctrl_d.resp_data  = pick_word(rd_line, head_addr[OFF_W-1:0]);
                    end else begin
                        ctrl_d.miss_store = 1'b0;
                        ctrl_d.miss_addr  = head_addr;
                        ctrl_d.state      = ST_START_MISS;
                    end
                end else if (!stq_empty && !stq_issued) begin
                    stq_issue = 1'b1;
                    if (stq_head_hit) begin
                        stq_deq      = 1'b1;
                        arr_wr_en    = 1'b1;
                        arr_wr_dirty = 1'b1;
                        arr_wr_idx   = stq_head_addr[OFF_W +: IDX_W];
                        arr_wr_tag   = rd_tag;
                        arr_wr_line  = merge_word(rd_line, stq_head_addr[OFF_W-1:0],
                                                  stq_head_data);
                    end else begin
                        ctrl_d.miss_store = 1'b1;
                        ctrl_d.miss_addr  = stq_head_addr;
                        ctrl_d.miss_data  = stq_head_data;
                        ctrl_d.state      = ST_START_MISS;
                    end
                end
            end
            ST_START_MISS: begin
                if (rd_valid && rd_dirty) begin
                    mem_req_valid = 1'b1;
                    mem_req_write = 1'b1;
                    mem_req_addr  = {rd_tag, ctrl_q.miss_addr[OFF_W +: IDX_W]};
                    if (mem_req_ready) ctrl_d.state = ST_SEND_FILL;
                end else begin
                    ctrl_d.state = ST_SEND_FILL;
                end
            end
            ST_SEND_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) ctrl_d.state = ST_WAIT_FILL;
            end
            default: begin
                if (mem_resp_valid) begin
                    arr_wr_en = 1'b1;
                    if (ctrl_q.miss_store) begin
                        stq_deq      = 1'b1;
                        arr_wr_dirty = 1'b1;
                        arr_wr_line  = merge_word(mem_resp_line, ctrl_q.miss_addr[OFF_W-1:0],
                                                  ctrl_q.miss_data);
                    end else begin
                        ctrl_d.resp_valid = 1'b1;
                        ctrl_d.resp_data  = pick_word(mem_resp_line, ctrl_q.miss_addr[OFF_W-1:0]);
                    end
                    ctrl_d.state = ST_READY;
                end else if (ctrl_q.miss_store && head_is_load) begin
                    if (srch_hit) begin
                        reqq_deq          = 1'b1;
                        ctrl_d.resp_valid = 1'b1;
                        ctrl_d.resp_data  = srch_data;
                    end else if (head_hit) begin
                        reqq_deq          = 1'b1;
                        ctrl_d.resp_valid = 1'b1;
                        ctrl_d.resp_data  = pick_word(rd_line, head_addr[OFF_W-1:0]);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_READY, miss_store: 1'b0, miss_addr: '0,
                        miss_data: '0, resp_valid: 1'b0, resp_data: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign resp_valid = ctrl_q.resp_valid;
    assign resp_data  = ctrl_q.resp_data;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
    import dcs_pkg::*;
#(
    parameter int LADDR_W = 30
) (
    input logic               clk,
    input logic               rst_n,
    input miss_state_e        state,
    input logic               miss_store,
    input logic               head_valid,
    input logic               head_store,
    input logic               stq_empty,
    input logic               stq_full,
    input logic               stq_issued,
    input logic               stq_issue,
    input logic               stq_enq,
    input logic               stq_deq,
    input logic               arr_wr_en,
    input logic               arr_wr_dirty,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [LADDR_W-1:0] mem_req_addr,
    input logic               mem_resp_valid,
    input logic               resp_valid
);
    // R3
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && head_valid && !head_store) |-> !stq_issue);

    // R4
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && head_valid && head_store && !stq_empty && !stq_issued)
        |-> stq_issue);

    // R5
    deq_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stq_deq |-> (arr_wr_en && arr_wr_dirty));

    // R2
    stq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stq_enq |-> (head_valid && head_store && !stq_full));

    // R7
    load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_FILL && !miss_store && !mem_resp_valid) |=> !resp_valid);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
endmodule

bind dcache_stbuf dcs_checker #(.LADDR_W(ADDR_W - $clog2(LINE_WORDS))) u_chk (
    .clk(clk), .rst_n(rst_n),
    .state(ctrl_q.state), .miss_store(ctrl_q.miss_store),
    .head_valid(head_valid), .head_store(head_store),
    .stq_empty(stq_empty), .stq_full(stq_full), .stq_issued(stq_issued),
    .stq_issue(stq_issue), .stq_enq(stq_enq), .stq_deq(stq_deq),
    .arr_wr_en(arr_wr_en), .arr_wr_dirty(arr_wr_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .resp_valid(resp_valid)
);

// File: tb/tb_dcache_stbuf.sv
module tb_dcache_stbuf;
    localparam int CLK_PERIOD = 10;
    localparam int SQD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_store = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         req_ready, resp_valid;
    logic [31:0]  resp_data;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b1;
    logic [29:0]  mem_req_addr;
    logic [127:0] mem_req_line;
    logic         mem_resp_valid = 1'b0;
    logic [127:0] mem_resp_line = '0;

    dcache_stbuf #(.SQ_DEPTH(SQD)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_line(mem_req_line),
        .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int acc_cyc = 0, last_resp_cyc = 0, fill_cyc = 0;
    int fill_lat = 2, stall_mode = 0, wr_count = 0, rd_n = 0;
    int rd_log [64];
    logic [31:0] mem_w [256];
    logic [31:0] ref_w [256];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial forever @(posedge clk) cyc++;

    // memory model: decides ready and serves requests at each negedge
    initial begin
        bit   pend = 1'b0, rdy;
        int   cnt = 0, paddr = 0;
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (pend) begin
                if (cnt <= 1) begin
                    for (int w = 0; w < 4; w++)
                        mem_resp_line[w*32 +: 32] = mem_w[paddr*4 + w];
                    mem_resp_valid = 1'b1;
                    pend = 1'b0;
                    fill_cyc = cyc;
                end else cnt--;
            end
            rdy = (stall_mode == 0) ? 1'b1 : (cyc % 2 == 0);
            mem_req_ready = rdy;
            if (rst_n && mem_req_valid && rdy) begin
                if (mem_req_write) begin
                    for (int w = 0; w < 4; w++)
                        mem_w[int'(mem_req_addr[5:0])*4 + w] = mem_req_line[w*32 +: 32];
                    wr_count++;
                end else begin
                    pend  = 1'b1;
                    cnt   = fill_lat;
                    paddr = int'(mem_req_addr[5:0]);
                    if (rd_n < 64) rd_log[rd_n] = paddr;
                    rd_n++;
                end
            end
        end
    end

    // response monitor against program-order reference
    initial forever begin
        @(negedge clk);
        if (rst_n && resp_valid) begin
            last_resp_cyc = cyc;
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected response", resp_data, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(resp_data == e, t, resp_data, e);
            end
        end
    end

    task automatic send(input bit st, input int a, input logic [31:0] d, input string tag);
        req_valid = 1'b1; req_store = st; req_addr = 32'(a); req_wdata = d;
        if (st) ref_w[a] = d;
        else begin exp_q.push_back(ref_w[a]); tag_q.push_back(tag); end
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
        chk(resp_valid == 1'b0, "R1 reset resp", 32'(resp_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R9 reset mem", 32'(mem_req_valid), 32'h0);
    endtask

    task automatic t_hit_latency();
        fill_lat = 2;
        send(0, 'h04, 0, "R9 cold load");
        settle(10);
        chk(wr_count == 0, "R9 clean victim no write", 32'(wr_count), 32'h0);
        send(0, 'h05, 0, "R1 hit data");
        settle(2);
        chk(last_resp_cyc == acc_cyc, "R1 hit latency", 32'(last_resp_cyc), 32'(acc_cyc));
    endtask

    task automatic t_younger_store();
        send(0, 'h06, 0, "R2 load before store");
        send(1, 'h06, 32'hAAAA_0006, "");
        send(0, 'h06, 0, "R2 load after store");
        settle(6);
    endtask

    task automatic t_youngest_match();
        fill_lat = 20;
        send(1, 'h48, 32'h1, "");
        send(1, 'h49, 32'h11, "");
        send(1, 'h49, 32'h22, "");
        settle(3);
        send(0, 'h49, 0, "R8 youngest store data");
        settle(2);
        chk(last_resp_cyc == acc_cyc, "R8 forward latency", 32'(last_resp_cyc), 32'(acc_cyc));
        settle(40);
    endtask

    task automatic t_deq_on_write();
        fill_lat = 20;
        send(1, 'h8C, 32'h55, "");
        settle(4);
        send(0, 'h8C, 0, "R5 forwarded data");
        settle(2);
        chk(last_resp_cyc == acc_cyc, "R5 store still queued", 32'(last_resp_cyc), 32'(acc_cyc));
        settle(30);
    endtask

    task automatic t_hit_under_store_miss();
        fill_lat = 20;
        send(1, 'hB0, 32'hB0B0, "");
        settle(4);
        send(0, 'h05, 0, "R6 hit data");
        settle(2);
        chk(last_resp_cyc == acc_cyc, "R6 hit under store miss", 32'(last_resp_cyc), 32'(acc_cyc));
        settle(30);
    endtask

    task automatic t_load_order();
        fill_lat = 15;
        send(0, 'hD4, 0, "R7 miss data");
        settle(3);
        send(0, 'h04, 0, "R7 hit data");
        settle(25);
        chk(last_resp_cyc > fill_cyc, "R7 hit after miss fill", 32'(last_resp_cyc), 32'(fill_cyc));
    endtask

    task automatic t_priority();
        int r0;
        fill_lat = 10;
        r0 = rd_n;
        send(1, 'h18, 32'h1818, "");
        send(1, 'h1C, 32'h1C1C, "");
        send(0, 'h50, 0, "R3 load data");
        settle(60);
        chk(rd_log[r0] == 'h06, "R3 first read", 32'(rd_log[r0]), 32'h06);
        chk(rd_log[r0+1] == 'h14, "R3 load read jumps store", 32'(rd_log[r0+1]), 32'h14);
        chk(rd_log[r0+2] == 'h07, "R3 second store read", 32'(rd_log[r0+2]), 32'h07);
    endtask

    task automatic t_drain();
        fill_lat = 3;
        for (int i = 0; i < SQD + 3; i++) send(1, 'h60 + i*5, 32'h111 * (i + 1), "");
        for (int i = 0; i < SQD + 3; i++) send(0, 'h60 + i*5, 0, "R4 drained store data");
        settle(120);
        chk(exp_q.size() == 0, "R4 all loads answered", 32'(exp_q.size()), 32'h0);
    endtask

    task automatic t_writeback();
        int w0;
        fill_lat = 3;
        send(1, 'h09, 32'h77, "");
        settle(20);
        w0 = wr_count;
        send(0, 'h29, 0, "R9 conflict load");
        settle(20);
        chk(wr_count == w0 + 1, "R9 dirty victim written", 32'(wr_count), 32'(w0 + 1));
        chk(mem_w['h09] == 32'h77, "R9 victim data", mem_w['h09], 32'h77);
        w0 = wr_count;
        send(0, 'h49, 0, "R9 reload");
        settle(20);
        chk(wr_count == w0, "R9 clean victim no write", 32'(wr_count), 32'(w0));
    endtask

    task automatic t_stall();
        stall_mode = 1;
        fill_lat = 4;
        send(1, 'hE9, 32'h99, "");
        settle(20);
        send(0, 'h09, 0, "R10 load under stall");
        settle(30);
        chk(mem_w['hE9] == 32'h99, "R10 write-back under stall", mem_w['hE9], 32'h99);
        send(0, 'hE9, 0, "R10 refetch");
        settle(30);
        chk(exp_q.size() == 0, "R10 all answered", 32'(exp_q.size()), 32'h0);
        stall_mode = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_w[i] = 32'h1000_0000 + 32'(i);
            ref_w[i] = 32'h1000_0000 + 32'(i);
        end
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_hit_latency();
        t_younger_store();
        t_youngest_match();
        t_deq_on_write();
        t_hit_under_store_miss();
        t_load_order();
        t_priority();
        t_drain();
        t_writeback();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule